// File: doc/BRIEF.md
# Stretchable External Memory Bus Sequencer

This block runs the data-memory cycles of an 8-bit controller on a port that carries the low address byte and then the data. For each accepted request it raises an address latch strobe while the low address byte is on the port. It then pulls a read or a write strobe low, moves the data, and reports completion with a one-cycle done pulse. The high address byte is presented on its own output for the whole access.

The block runs from an internal clock at twice the oscillator rate, so one internal cycle is half an oscillator period and all timing below is counted in internal cycles. A 3-bit stretch code, held in a small configuration register, lengthens each access in steps of four oscillator periods (eight internal cycles). Codes 000 to 111 give accesses of 2 to 9 machine cycles. A nonzero code also moves the strobe one half period later relative to the latch strobe and adds a short gap before the bus is free again.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is low, and after it, until a request is accepted: `ale`=0, `rd_n`=1, `wr_n`=1, `port_oe`=0, `done`=0.
- R2: A request is accepted on the clock edge at which `req`=1 and the block is idle. `ale` is high for exactly 3 cycles, starting in the cycle after acceptance. `port_oe`=1 and `port_out`=addr[7:0] during those 3 cycles and during the 1 cycle after `ale` falls. `addr_hi`=addr[15:8] throughout the access.
- R3: The strobe falls 1 cycle after `ale` falls when the code is 0, and 2 cycles after when it is nonzero.
- R4: The strobe stays low for 4 cycles when the code is 0, and for 8 × code cycles otherwise.
- R5: The stretch register resets to 001 and loads `stretch_in` when `set_stretch`=1. If `set_stretch` is high in the cycle in which a request is accepted, the new code governs that access.
- R6: The code is captured at acceptance. A stretch write during an access affects only later accesses.
- R7: Write (`is_read`=0): only `wr_n` pulses low. From the cycle after the address hold until 2 cycles after `wr_n` rises, `port_oe`=1 and `port_out`=wdata.
- R8: Read (`is_read`=1): only `rd_n` pulses low. `port_oe`=0 from the end of the address hold until done. `rdata` takes the `port_in` value present in the last cycle of `rd_n` low, sampled at the edge where `rd_n` rises.
- R9: After the strobe rises, done follows after 0 cycles for a read with code 0, and after 2 cycles in all other cases. `done` is high for exactly one cycle, which is the first idle cycle.
- R10: `req` is ignored while busy; the done cycle counts as idle, so a held request starts the next `ale` in the cycle after `done`. `rd_n` and `wr_n` are never low together, nor while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stretch | input | 1 | Load `stretch_in` into the stretch register |
| stretch_in | input | 3 | New stretch code |
| req | input | 1 | Access request |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| port_in | input | 8 | Value seen on the shared port |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| port_oe | output | 1 | Port drive enable |
| port_out | output | 8 | Value driven on the shared port |
| addr_hi | output | 8 | High address byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |

## Verification
Two events can fall in the same cycle: a write to the stretch register, and the acceptance of a request. The bench raises `set_stretch` in the very cycle that `req` is taken and judges which code governed the access from the measured gap and strobe width. It does the same with a write placed in the middle of an access, expecting the old width now and the new width on the following access. A second collision, a held request landing in the done cycle, is judged by `ale` rising in the next cycle.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter logic [2:0] STRETCH_RST = 3'b001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_stretch,
  input  logic [2:0] stretch_in,
  input  logic       req,
  input  logic       is_read,
  input  logic [15:0] addr,
  input  logic [7:0] wdata,
  input  logic [7:0] port_in,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       port_oe,
  output logic [7:0] port_out,
  output logic [7:0] addr_hi,
  output logic       done,
  output logic [7:0] rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ALE, S_AHLD, S_GAP, S_STRB, S_TAIL} st_t;

  st_t         st;
  logic [5:0]  cnt;
  logic [2:0]  cfg, cur;
  logic        rd;
  logic [15:0] a;
  logic [7:0]  wd;
  logic [2:0]  eff;

  assign eff = set_stretch ? stretch_in : cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cfg   <= STRETCH_RST;
      cur   <= '0;
      rd    <= 1'b0;
      a     <= '0;
      wd    <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (set_stretch) cfg <= stretch_in;
      case (st)
        S_IDLE: if (req) begin
          cur <= eff;
          rd  <= is_read;
          a   <= addr;
          wd  <= wdata;
          cnt <= 6'd2;
          st  <= S_ALE;
        end
        S_ALE: if (cnt == 6'd0) st <= S_AHLD; else cnt <= cnt - 6'd1;
        S_AHLD: if (cur == 3'd0) begin
          cnt <= 6'd3;
          st  <= S_STRB;
        end else st <= S_GAP;
        S_GAP: begin
          cnt <= {cur, 3'b000} - 6'd1;
          st  <= S_STRB;
        end
        S_STRB: if (cnt == 6'd0) begin
          if (rd) rdata <= port_in;
          if (rd && cur == 3'd0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= 6'd1;
            st  <= S_TAIL;
          end
        end else cnt <= cnt - 6'd1;
        S_TAIL: if (cnt == 6'd0) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 6'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic addr_ph, data_ph;
  assign addr_ph  = (st == S_ALE) || (st == S_AHLD);
  assign data_ph  = (st == S_GAP) || (st == S_STRB) || (st == S_TAIL);
  assign ale      = (st == S_ALE);
  assign rd_n     = !((st == S_STRB) && rd);
  assign wr_n     = !((st == S_STRB) && !rd);
  assign port_oe  = addr_ph || (data_ph && !rd);
  assign port_out = addr_ph ? a[7:0] : wd;
  assign addr_hi  = a[15:8];

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R10
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n)); // R10
  AST_RD_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !port_oe); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(ale) |-> ($past(ale, 2) && $past(ale, 3))); // R2
  AST_STRB_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(rd_n) || $fell(wr_n)) |-> !$past(ale)); // R3

endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_stretch = 1'b0, req = 1'b0, is_read = 1'b0;
  logic [2:0] stretch_in = '0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, port_in = '0;
  logic ale, rd_n, wr_n, port_oe, done;
  logic [7:0] port_out, addr_hi, rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;

  ext_bus_seq u0 (.clk(clk), .rst_n(rst_n), .set_stretch(set_stretch), .stretch_in(stretch_in),
    .req(req), .is_read(is_read), .addr(addr), .wdata(wdata), .port_in(port_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .port_oe(port_oe), .port_out(port_out),
    .addr_hi(addr_hi), .done(done), .rdata(rdata));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_cfg(input logic [2:0] c);
    @(negedge clk);
    set_stretch = 1'b1; stretch_in = c;
    @(negedge clk);
    set_stretch = 1'b0;
  endtask

  // mid_code < 0: no stretch write during the access
  task automatic run_access(input bit rdx, input logic [15:0] ad, input logic [7:0] wd,
                            input logic [7:0] rdv, input int code, input bit cfg_now,
                            input int mid_code, input bit poke, input bit hold);
    int n_ale, n_pre, n_strb, n_post, smp;
    bit seen_ale, seen_strb, port_ok, hi_ok, got_done, strobe_ok;
    int exp_strb;
    exp_strb = (code == 0) ? 4 : 8 * code;
    n_ale = 0; n_pre = 0; n_strb = 0; n_post = 0; smp = 0;
    seen_ale = 0; seen_strb = 0; port_ok = 1; hi_ok = 1; got_done = 0; strobe_ok = 1;
    @(negedge clk);
    req = 1'b1; is_read = rdx; addr = ad; wdata = wd; port_in = ~rdv;
    if (cfg_now) begin set_stretch = 1'b1; stretch_in = code[2:0]; end
    @(negedge clk);
    set_stretch = 1'b0;
    if (!hold) req = 1'b0;
    while (!got_done && smp < 200) begin
      smp++;
      if (mid_code >= 0) begin
        set_stretch = (smp == 2);
        stretch_in = mid_code[2:0];
      end
      if (poke) begin req = (smp == 5); is_read = ~rdx; end
      if (done) got_done = 1;
      else begin
        if (addr_hi != ad[15:8]) hi_ok = 0;
        if ((rdx && !wr_n) || (!rdx && !rd_n)) strobe_ok = 0;
        if (ale) begin
          n_ale++; seen_ale = 1;
          if (!(port_oe && port_out == ad[7:0])) port_ok = 0;
        end else if (seen_ale && !seen_strb && rd_n && wr_n) begin
          n_pre++;
          if (n_pre == 1) begin
            if (!(port_oe && port_out == ad[7:0])) port_ok = 0;
          end else if (rdx ? port_oe : !(port_oe && port_out == wd)) port_ok = 0;
        end else if (!rd_n || !wr_n) begin
          n_strb++; seen_strb = 1;
          if (rdx ? port_oe : !(port_oe && port_out == wd)) port_ok = 0;
          port_in = (n_strb == exp_strb) ? rdv : ~rdv;
        end else if (seen_strb) begin
          n_post++;
          if (rdx ? port_oe : !(port_oe && port_out == wd)) port_ok = 0;
        end
        @(negedge clk);
      end
    end
    set_stretch = 1'b0;
    chk(got_done, "R9 done seen", got_done, 1);
    chk(n_ale == 3, "R2 ale width", n_ale, 3);
    chk(hi_ok, "R2 addr_hi", addr_hi, ad[15:8]);
    chk(n_pre == ((code == 0) ? 1 : 2), "R3 strobe delay", n_pre, (code == 0) ? 1 : 2);
    chk(n_strb == exp_strb, "R4 strobe width", n_strb, exp_strb);
    chk(strobe_ok, rdx ? "R8 strobe kind" : "R7 strobe kind", strobe_ok, 1);
    chk(port_ok, rdx ? "R8 port off" : "R7 port data", port_ok, 1);
    chk(n_post == ((rdx && code == 0) ? 0 : 2), "R9 tail", n_post, (rdx && code == 0) ? 0 : 2);
    if (rdx) chk(rdata == rdv, "R8 rdata", rdata, rdv);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    if (hold) begin
      chk(ale, "R10 held request starts next ale", ale, 1);
      req = 1'b0;
      smp = 0;
      while (!done && smp < 200) begin smp++; @(negedge clk); end
    end
  endtask

  // {is_read, code, addr, wdata, read value}
  localparam logic [35:0] VEC [0:7] = '{
    {1'b0, 3'd0, 16'h12A5, 8'h3C, 8'h00},
    {1'b1, 3'd0, 16'hF00F, 8'h00, 8'h96},
    {1'b1, 3'd1, 16'h8001, 8'h00, 8'h5A},
    {1'b0, 3'd2, 16'h4C33, 8'hE1, 8'h00},
    {1'b1, 3'd3, 16'h00FF, 8'h00, 8'hC3},
    {1'b0, 3'd4, 16'hABCD, 8'h7E, 8'h00},
    {1'b1, 3'd6, 16'h7710, 8'h00, 8'h18},
    {1'b0, 3'd7, 16'hFFFF, 8'h81, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && !port_oe && !done, "R1 reset outputs", {ale, rd_n, wr_n, port_oe, done}, 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !port_oe && !done, "R1 idle after reset", {ale, rd_n, wr_n, port_oe, done}, 5'b01100);
    // R5: reset code 001 without any write
    run_access(1'b1, 16'h2468, 8'h00, 8'hA7, 1, 1'b0, -1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      set_cfg(VEC[i][34:32]);
      run_access(VEC[i][35], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0],
                 int'(VEC[i][34:32]), 1'b0, -1, 1'b0, 1'b0);
    end
    // R5: write coincides with acceptance
    set_cfg(3'd2);
    run_access(1'b0, 16'h1357, 8'h9B, 8'h00, 5, 1'b1, -1, 1'b0, 1'b0);
    // R6: write during access only affects next one
    set_cfg(3'd0);
    run_access(1'b1, 16'h0A0B, 8'h00, 8'h44, 0, 1'b0, 6, 1'b0, 1'b0);
    run_access(1'b1, 16'h0C0D, 8'h00, 8'h55, 6, 1'b0, -1, 1'b0, 1'b0);
    // R10: request pulse while busy is ignored
    set_cfg(3'd1);
    run_access(1'b0, 16'h3344, 8'h66, 8'h00, 1, 1'b0, -1, 1'b1, 1'b0);
    begin
      bit quiet = 1;
      for (int k = 0; k < 6; k++) begin
        if (ale || !rd_n || !wr_n) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R10 busy request ignored", quiet, 1);
    end
    // R10: held request accepted in done cycle
    set_cfg(3'd0);
    run_access(1'b1, 16'h5566, 8'h00, 8'h77, 0, 1'b0, -1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule